// File: doc/BRIEF.md
# NAND Page DMA Engine

This block moves one flash page between system memory and the flash operation sequencer. A page is made of two regions, a main data area of fixed size and a spare area of programmable length. Each region has its own memory base address and its own enable, so software can move the whole page, only the main data, or only the spare bytes, and the two regions need not be next to each other in memory.

Software writes the two base addresses, the spare length, an interrupt enable, and a control word that holds the direction, the region enables, the chip select and a start bit. Setting start launches the transfer. The start bit reads back as 1 while the engine is busy and drops to 0 when it is done. At that point a completion status bit is set. This bit drives the interrupt output through its enable, and software clears it by writing 1. Memory is reached through a single-word request/acknowledge port. Flash bytes move over a valid/ready byte stream in each direction.

Register offsets on the 5-bit register address: 0x00 control, 0x04 data-area base, 0x08 spare-area base, 0x0C length, 0x10 interrupt enable, 0x14 interrupt status (read), 0x18 interrupt clear (write). Reads are combinational.

Top module: `nand_page_dma`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0, and `mem_req_o`, `fl_tx_valid_o` and `fl_rx_ready_o` are 0.
- R2: Writing control with bit 0 set while idle starts a transfer. Control bit 0 reads 1 while the transfer runs and 0 once it has finished.
- R3: With control bit 1 set (program), each memory word is read and sent on `fl_tx_data_o` least significant byte first. With bit 1 clear (read), bytes from `fl_rx_data_i` are packed least significant byte first into words that are written to memory.
- R4: Control bit 2 enables the data area, which is DATA_BYTES bytes at the data base. Control bit 3 enables the spare area at the spare base. A disabled area moves no bytes.
- R5: The data area is moved before the spare area. Words within an area use consecutive addresses 4 apart, starting at the area's own base. The low two bits of both bases are ignored and read back as 0.
- R6: The spare length is a 12-bit byte count at length-register bits [27:16]. It is rounded down to whole words, a length under 4 moves nothing, and the field reads back as written.
- R7: Completion sets interrupt status bit 9. `irq_o` is status bit 9 AND enable bit 9. Writing 1 to clear-register bit 9 clears the status, and writing other bits does not clear it.
- R8: A control write while bit 0 reads 1 is ignored entirely: neither the readback nor the running transfer changes.
- R9: A start with both area enables clear finishes without memory or flash traffic and still sets status bit 9.
- R10: `fl_cs_o` follows control bits [9:8]. Control bits [9:4] (bits [6:4] burst-size enables, bit 7 long-address flag) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at reg_addr_i |
| irq_o | output | 1 | Completion interrupt |
| mem_req_o | output | 1 | Memory word request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| fl_cs_o | output | 2 | Selected flash chip |
| fl_tx_valid_o | output | 1 | Byte toward flash valid |
| fl_tx_data_o | output | 8 | Byte toward flash |
| fl_tx_ready_i | input | 1 | Flash side accepts byte |
| fl_rx_valid_i | input | 1 | Byte from flash valid |
| fl_rx_data_i | input | 8 | Byte from flash |
| fl_rx_ready_o | output | 1 | Engine accepts byte |

## Verification
Program transfers with both areas enabled, with a non-contiguous spare base, and with stalling flash-ready and memory-acknowledge patterns separate a correct byte order and area order from swapped lanes, missing pointer steps or a spare area that wrongly continues from the data area. Read transfers with gaps in the flash byte stream show whether word packing and write addressing hold up under backpressure. A data-only program with a nonzero spare length, a spare-only read with a length that is not a whole number of words, and a start with no area enabled tell apart correct gating from extra or missing bytes. A control write during a running transfer, together with the sequence of mask, clear and enable writes, shows that busy writes are ignored and that the interrupt is gated correctly.

// File: rtl/nd_pkg.sv
package nd_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_DBASE = 5'h04;
  localparam logic [REG_AW-1:0] OFF_SBASE = 5'h08;
  localparam logic [REG_AW-1:0] OFF_LEN   = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_IEN   = 5'h10;
  localparam logic [REG_AW-1:0] OFF_ISTAT = 5'h14;
  localparam logic [REG_AW-1:0] OFF_ICLR  = 5'h18;
  localparam int DONE_BIT  = 9;
  localparam int SPLEN_LSB = 16;
  localparam int SPLEN_W   = 12;

  // control bits [9:1], MSB first
  typedef struct packed {
    logic [1:0] cs;
    logic       addr_long;
    logic [2:0] burst;
    logic       spare_en;
    logic       data_en;
    logic       to_flash;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SEND, ST_RECV, ST_STORE, ST_FINISH
  } mv_state_e;
endpackage

// File: rtl/nd_regs.sv
module nd_regs
  import nd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [REG_AW-1:0]      reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic                   done_i,
  output ctrl_t                  ctrl_o,
  output logic                   start_o,
  output logic                   go_o,
  output logic [AW-3:0]          dbase_o,
  output logic [AW-3:0]          sbase_o,
  output logic [SPLEN_W-3:0]     sp_words_o,
  output logic                   istat_o,
  output logic                   irq_o
);
  ctrl_t              ctrl_q;
  logic               start_q, go_q, ien_q, istat_q;
  logic [AW-3:0]      dbase_q, sbase_q;
  logic [SPLEN_W-1:0] splen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
      go_q    <= 1'b0;
      ien_q   <= 1'b0;
      istat_q <= 1'b0;
      dbase_q <= '0;
      sbase_q <= '0;
      splen_q <= '0;
    end else begin
      go_q <= 1'b0;
      if (done_i) start_q <= 1'b0;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          OFF_CTRL: if (!start_q) begin
            ctrl_q <= ctrl_t'(reg_wdata_i[9:1]);
            if (reg_wdata_i[0]) begin
              start_q <= 1'b1;
              go_q    <= 1'b1;
            end
          end
          OFF_DBASE: dbase_q <= reg_wdata_i[AW-1:2];
          OFF_SBASE: sbase_q <= reg_wdata_i[AW-1:2];
          OFF_LEN:   splen_q <= reg_wdata_i[SPLEN_LSB +: SPLEN_W];
          OFF_IEN:   ien_q   <= reg_wdata_i[DONE_BIT];
          OFF_ICLR:  if (reg_wdata_i[DONE_BIT]) istat_q <= 1'b0;
          default: ;
        endcase
      end
      // completion wins over a same-cycle clear
      if (done_i) istat_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_CTRL:  reg_rdata_o = {22'b0, ctrl_q, start_q};
      OFF_DBASE: reg_rdata_o = 32'({dbase_q, 2'b00});
      OFF_SBASE: reg_rdata_o = 32'({sbase_q, 2'b00});
      OFF_LEN:   reg_rdata_o = 32'(splen_q) << SPLEN_LSB;
      OFF_IEN:   reg_rdata_o = 32'(ien_q) << DONE_BIT;
      OFF_ISTAT: reg_rdata_o = 32'(istat_q) << DONE_BIT;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign start_o    = start_q;
  assign go_o       = go_q;
  assign dbase_o    = dbase_q;
  assign sbase_o    = sbase_q;
  assign sp_words_o = splen_q[SPLEN_W-1:2];
  assign istat_o    = istat_q;
  assign irq_o      = istat_q & ien_q;
endmodule

// File: rtl/nd_mover.sv
module nd_mover
  import nd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DATA_BYTES = 2048
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic               to_flash_i,
  input  logic               data_en_i,
  input  logic               spare_en_i,
  input  logic [AW-3:0]      dbase_i,
  input  logic [AW-3:0]      sbase_i,
  input  logic [SPLEN_W-3:0] sp_words_i,
  output logic               done_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        mem_rdata_i,
  input  logic               mem_ack_i,
  output logic               fl_tx_valid_o,
  output logic [7:0]         fl_tx_data_o,
  input  logic               fl_tx_ready_i,
  input  logic               fl_rx_valid_i,
  input  logic [7:0]         fl_rx_data_i,
  output logic               fl_rx_ready_o
);
  localparam int DATA_WORDS = DATA_BYTES / 4;
  localparam int SP_MAX     = (1 << (SPLEN_W - 2)) - 1;
  localparam int MAXW       = (DATA_WORDS > SP_MAX) ? DATA_WORDS : SP_MAX;
  localparam int CW         = $clog2(MAXW + 1);

  mv_state_e     st_q;
  logic          area_q;      // 0 data, 1 spare
  logic [AW-3:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   buf_q;
  logic [1:0]    lane_q;

  logic [CW-1:0] sp_cnt;
  logic          sp_go, word_done;
  mv_state_e     first_st;

  assign sp_cnt    = CW'(sp_words_i);
  assign sp_go     = spare_en_i && (sp_words_i != '0);
  assign first_st  = to_flash_i ? ST_FETCH : ST_RECV;
  assign word_done = (st_q == ST_SEND && fl_tx_ready_i && lane_q == 2'd3) ||
                     (st_q == ST_STORE && mem_ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      area_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      buf_q  <= '0;
      lane_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go_i) begin
          lane_q <= '0;
          if (data_en_i) begin
            area_q <= 1'b0;
            addr_q <= dbase_i;
            cnt_q  <= CW'(DATA_WORDS);
            st_q   <= first_st;
          end else if (sp_go) begin
            area_q <= 1'b1;
            addr_q <= sbase_i;
            cnt_q  <= sp_cnt;
            st_q   <= first_st;
          end else begin
            st_q   <= ST_FINISH;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          buf_q <= mem_rdata_i;
          st_q  <= ST_SEND;
        end
        ST_SEND: if (fl_tx_ready_i) lane_q <= lane_q + 2'd1;
        ST_RECV: if (fl_rx_valid_i) begin
          buf_q[{lane_q, 3'b000} +: 8] <= fl_rx_data_i;
          lane_q <= lane_q + 2'd1;
          if (lane_q == 2'd3) st_q <= ST_STORE;
        end
        ST_STORE: ;
        ST_FINISH: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase

      if (word_done) begin
        if (cnt_q == CW'(1)) begin
          if (!area_q && sp_go) begin
            area_q <= 1'b1;
            addr_q <= sbase_i;
            cnt_q  <= sp_cnt;
            st_q   <= first_st;
          end else begin
            st_q <= ST_FINISH;
          end
        end else begin
          addr_q <= addr_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          st_q   <= first_st;
        end
      end
    end
  end

  assign mem_req_o     = (st_q == ST_FETCH) || (st_q == ST_STORE);
  assign mem_we_o      = (st_q == ST_STORE);
  assign mem_addr_o    = {addr_q, 2'b00};
  assign mem_wdata_o   = buf_q;
  assign fl_tx_valid_o = (st_q == ST_SEND);
  assign fl_tx_data_o  = buf_q[{lane_q, 3'b000} +: 8];
  assign fl_rx_ready_o = (st_q == ST_RECV);
  assign done_o        = (st_q == ST_FINISH);
endmodule

// File: rtl/nand_page_dma.sv
module nand_page_dma
  import nd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DATA_BYTES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [1:0]        fl_cs_o,
  output logic              fl_tx_valid_o,
  output logic [7:0]        fl_tx_data_o,
  input  logic              fl_tx_ready_i,
  input  logic              fl_rx_valid_i,
  input  logic [7:0]        fl_rx_data_i,
  output logic              fl_rx_ready_o
);
  ctrl_t              ctrl_w;
  logic               start_w, go_w, done_w, istat_w, dir_w;
  logic [AW-3:0]      dbase_w, sbase_w;
  logic [SPLEN_W-3:0] sp_words_w;

  nd_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .done_i(done_w), .ctrl_o(ctrl_w), .start_o(start_w), .go_o(go_w),
    .dbase_o(dbase_w), .sbase_o(sbase_w), .sp_words_o(sp_words_w),
    .istat_o(istat_w), .irq_o
  );

  assign dir_w   = ctrl_w.to_flash;
  assign fl_cs_o = ctrl_w.cs;

  nd_mover #(.AW(AW), .DATA_BYTES(DATA_BYTES)) u_mover (
    .clk_i, .rst_ni, .go_i(go_w), .to_flash_i(dir_w),
    .data_en_i(ctrl_w.data_en), .spare_en_i(ctrl_w.spare_en),
    .dbase_i(dbase_w), .sbase_i(sbase_w), .sp_words_i(sp_words_w),
    .done_o(done_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .fl_tx_valid_o, .fl_tx_data_o, .fl_tx_ready_i,
    .fl_rx_valid_i, .fl_rx_data_i, .fl_rx_ready_o
  );
endmodule

// File: rtl/nd_chk.sv
module nd_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          mem_ack_i,
  input logic          tx_valid_i,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_i,
  input logic          rx_ready_i,
  input logic          start_i,
  input logic          dir_i,
  input logic          done_i,
  input logic          istat_i
);
  // R3
  tx_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |-> dir_i);
  // R3
  rx_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i |-> !dir_i);
  // R3
  we_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> !dir_i);
  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i) |=> (tx_valid_i && $stable(tx_data_i)));
  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_ack_i) |=> (mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i)));
  // R5
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (mem_addr_i[1:0] == 2'b00));
  // R2
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i || tx_valid_i || rx_ready_i) |-> start_i);
  // R2
  start_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_i) |-> $past(done_i));
  // R7
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> istat_i);
endmodule

bind nand_page_dma nd_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_req_i(mem_req_o), .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o),
  .mem_ack_i(mem_ack_i),
  .tx_valid_i(fl_tx_valid_o), .tx_ready_i(fl_tx_ready_i), .tx_data_i(fl_tx_data_o),
  .rx_ready_i(fl_rx_ready_o),
  .start_i(start_w), .dir_i(dir_w), .done_i(done_w), .istat_i(istat_w)
);

// File: tb/sim_nand_page_dma.sv
module sim_nand_page_dma;
  localparam int CLK_P = 10;
  localparam int DW    = 512;  // data words for the default 2048-byte area

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        mem_ack_i;
  logic [1:0]  fl_cs_o;
  logic        fl_tx_valid_o;
  logic [7:0]  fl_tx_data_o;
  logic        fl_tx_ready_i;
  logic        fl_rx_valid_i;
  logic [7:0]  fl_rx_data_i;
  logic        fl_rx_ready_o;

  always #(CLK_P/2) clk = ~clk;

  nand_page_dma u0 (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .irq_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .mem_ack_i, .fl_cs_o, .fl_tx_valid_o, .fl_tx_data_o, .fl_tx_ready_i,
    .fl_rx_valid_i, .fl_rx_data_i, .fl_rx_ready_o
  );

  int checks = 0;
  int errors = 0;
  string tag = "R3";
  logic [31:0] mem [4096];
  logic [7:0]  exp_bq [$];   // bytes expected toward flash
  logic [7:0]  src_q  [$];   // bytes offered from flash
  logic [63:0] exp_wq [$];   // {addr, data} expected memory writes

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    v = 32'h1;
    while (v[0] && n < 20000) begin
      rd(5'h00, v);
      n++;
    end
    chk(v[0] == 1'b0, req, "start bit clears at completion", 64'(v[0]), 64'd0);
  endtask

  // memory model: variable latency, scoreboard for writes
  initial begin
    int lat = 0;
    int seq = 0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      mem_ack_i = 1'b0;
      if (mem_req_o) begin
        if (lat > 0) lat--;
        else begin
          mem_ack_i = 1'b1;
          if (mem_we_o) begin
            if (exp_wq.size() == 0)
              chk(1'b0, tag, "unexpected memory write", {mem_addr_o, mem_wdata_o}, 64'd0);
            else begin
              logic [63:0] e;
              e = exp_wq.pop_front();
              chk({mem_addr_o, mem_wdata_o} == e, tag, "memory write", {mem_addr_o, mem_wdata_o}, e);
            end
            mem[mem_addr_o[13:2]] = mem_wdata_o;
          end else begin
            mem_rdata_i = mem[mem_addr_o[13:2]];
          end
          lat = seq;
          seq = (seq + 1) % 3;
        end
      end
    end
  end

  // flash-side byte sink with backpressure (monitor)
  initial begin
    int cyc = 0;
    fl_tx_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      fl_tx_ready_i = (cyc % 3) != 0;
      if (fl_tx_valid_o && fl_tx_ready_i) begin
        if (exp_bq.size() == 0)
          chk(1'b0, tag, "unexpected flash byte", 64'(fl_tx_data_o), 64'd0);
        else begin
          logic [7:0] e;
          e = exp_bq.pop_front();
          chk(fl_tx_data_o == e, tag, "flash byte", 64'(fl_tx_data_o), 64'(e));
        end
      end
    end
  end

  // flash-side byte source with gaps
  initial begin
    int k = 0;
    fl_rx_valid_i = 1'b0;
    fl_rx_data_i = '0;
    forever begin
      @(negedge clk);
      k++;
      if (src_q.size() > 0 && (k % 4) != 0) begin
        fl_rx_valid_i = 1'b1;
        fl_rx_data_i = src_q[0];
        if (fl_rx_ready_o) void'(src_q.pop_front());
      end else begin
        fl_rx_valid_i = 1'b0;
      end
    end
  end

  function automatic logic [31:0] pat(input int seed, input int i);
    return (32'(seed) << 24) ^ (32'(i) * 32'h0103_0507) ^ 32'h5A3C_0000;
  endfunction

  // driver: program (memory to flash)
  task automatic run_prog(input logic [31:0] db, input logic [31:0] sb, input int splen,
                          input bit den, input bit sen, input logic [1:0] cs,
                          input logic [31:0] extra, input bit poke, input int seed);
    logic [31:0] cv, v;
    if (den)
      for (int i = 0; i < DW; i++) begin
        logic [31:0] w = pat(seed, i);
        mem[db[13:2] + 12'(i)] = w;
        for (int b = 0; b < 4; b++) exp_bq.push_back(w[8*b +: 8]);
      end
    if (sen)
      for (int i = 0; i < splen / 4; i++) begin
        logic [31:0] w = pat(seed + 7, i) ^ 32'hFFFF_0000;
        mem[sb[13:2] + 12'(i)] = w;
        for (int b = 0; b < 4; b++) exp_bq.push_back(w[8*b +: 8]);
      end
    wr(5'h04, db);
    wr(5'h08, sb);
    wr(5'h0C, 32'(splen) << 16);
    cv = 32'h3 | extra | (32'(den) << 2) | (32'(sen) << 3) | (32'(cs) << 8);
    wr(5'h00, cv);
    rd(5'h00, v);
    chk(v[0] == 1'b1, "R2", "start bit set while running", 64'(v[0]), 64'd1);
    chk(fl_cs_o == cs, "R10", "chip select output", 64'(fl_cs_o), 64'(cs));
    if (poke) begin
      repeat (20) @(negedge clk);
      wr(5'h00, cv ^ 32'h0000_030E);
      rd(5'h00, v);
      chk(v == cv, "R8", "control write while busy ignored", 64'(v), 64'(cv));
    end
    wait_idle("R2");
    chk(exp_bq.size() == 0, "R4", "all expected flash bytes sent", 64'(exp_bq.size()), 64'd0);
  endtask

  // driver: read (flash to memory)
  task automatic run_read(input logic [31:0] db, input logic [31:0] sb, input int splen,
                          input bit den, input bit sen, input logic [1:0] cs, input int seed);
    logic [31:0] cv;
    if (den)
      for (int i = 0; i < DW; i++) begin
        logic [31:0] w = pat(seed, i);
        for (int b = 0; b < 4; b++) src_q.push_back(w[8*b +: 8]);
        exp_wq.push_back({db + 32'(4 * i), w});
      end
    if (sen)
      for (int i = 0; i < splen / 4; i++) begin
        logic [31:0] w = pat(seed + 3, i) ^ 32'h00FF_00FF;
        for (int b = 0; b < 4; b++) src_q.push_back(w[8*b +: 8]);
        exp_wq.push_back({sb + 32'(4 * i), w});
      end
    wr(5'h04, db);
    wr(5'h08, sb);
    wr(5'h0C, 32'(splen) << 16);
    cv = 32'h1 | (32'(den) << 2) | (32'(sen) << 3) | (32'(cs) << 8);
    wr(5'h00, cv);
    chk(fl_cs_o == cs, "R10", "chip select output", 64'(fl_cs_o), 64'(cs));
    wait_idle("R2");
    chk(exp_wq.size() == 0, "R3", "all expected memory writes seen", 64'(exp_wq.size()), 64'd0);
    chk(src_q.size() == 0, "R6", "all flash bytes consumed", 64'(src_q.size()), 64'd0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    repeat (148000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(4 * a), v);
      chk(v == 32'h0, "R1", "register reads 0 after reset", 64'(v), 64'd0);
    end
    chk({irq_o, mem_req_o, fl_tx_valid_o, fl_rx_ready_o} == 4'b0, "R1", "outputs idle after reset",
        64'({irq_o, mem_req_o, fl_tx_valid_o, fl_rx_ready_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    rd(5'h00, v);
    chk(v == 32'h0, "R1", "control 0 after reset release", 64'(v), 64'd0);

    // R3 R4 R5: program both areas, spare base not following data area
    tag = "R3/R5 program both areas";
    run_prog(32'h0000_1000, 32'h0000_3000, 16, 1'b1, 1'b1, 2'd1, 32'h0000_00F0, 1'b0, 1);
    rd(5'h00, v);
    chk(v == 32'h0000_01FE, "R10", "control readback after completion", 64'(v), 64'h1FE);
    rd(5'h14, v);
    chk(v == 32'h0000_0200, "R7", "completion status set", 64'(v), 64'h200);
    chk(irq_o == 1'b0, "R7", "irq masked while enable clear", 64'(irq_o), 64'd0);

    // R7 enable, partial clear, clear
    wr(5'h10, 32'h0000_0200);
    @(negedge clk);
    chk(irq_o == 1'b1, "R7", "irq after enable", 64'(irq_o), 64'd1);
    wr(5'h18, 32'h0000_0100);
    rd(5'h14, v);
    chk(v == 32'h0000_0200, "R7", "clear with bit 9 zero keeps status", 64'(v), 64'h200);
    wr(5'h18, 32'h0000_0200);
    rd(5'h14, v);
    chk(v == 32'h0, "R7", "write-1 clear", 64'(v), 64'd0);
    chk(irq_o == 1'b0, "R7", "irq drops after clear", 64'(irq_o), 64'd0);

    // R3 R5: read both areas, unaligned base low bits ignored
    tag = "R3/R5 read both areas";
    wr(5'h08, 32'h0000_3003);
    rd(5'h08, v);
    chk(v == 32'h0000_3000, "R5", "base low bits read as 0", 64'(v), 64'h3000);
    run_read(32'h0000_1000, 32'h0000_3000, 32, 1'b1, 1'b1, 2'd2, 5);
    chk(irq_o == 1'b1, "R7", "irq after read completion", 64'(irq_o), 64'd1);
    wr(5'h18, 32'h0000_0200);

    // R4 R8: data-only program with nonzero spare length, busy control write
    tag = "R4/R8 data-only program";
    run_prog(32'h0000_1000, 32'h0000_3000, 64, 1'b1, 1'b0, 2'd3, 32'h0, 1'b1, 9);

    // R6: spare-only read, length not a whole number of words
    tag = "R6 spare-only read";
    run_read(32'h0000_1000, 32'h0000_3100, 14, 1'b0, 1'b1, 2'd0, 11);
    rd(5'h0C, v);
    chk(v == 32'h000E_0000, "R6", "length field readback", 64'(v), 64'h000E_0000);

    // R9: no area enabled
    tag = "R9 empty transfer";
    wr(5'h18, 32'h0000_0200);
    wr(5'h00, 32'h0000_0001);
    wait_idle("R9");
    rd(5'h14, v);
    chk(v == 32'h0000_0200, "R9", "status set by empty transfer", 64'(v), 64'h200);
    chk(irq_o == 1'b1, "R9", "irq after empty transfer", 64'(irq_o), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule